// File: doc/BRIEF.md
# Paged Output Selector Front End

This block sits between eight pins and a large bank of logic under test. It has one clock pin, one mode pin and six shared data pins. On each rising clock edge the six data pins are written into one of two registers. The mode pin, sampled on that same edge, picks which one. One register, the stimulus register, drives the same 6-bit stimulus to every unit under test in parallel. The other, the page register, picks which group of eight result bits is sent to the eight output pins.

The units under test are outside this block. They are seen only as a 432-bit result bus, which holds 54 pages of eight bits each. To use the block, first load a page number with the mode pin high. Then load stimulus values with the mode pin low, and read the chosen results on the output pins.

Top module: `page_sel_front`

## Requirements
- R1: A synchronous active-high reset clears both the page register and the stimulus register to zero. After reset, `stim` is 0 and `out_pins` shows page 0.
- R2: On a rising edge with `mode_pg` high, `pin_data` is loaded into the page register and `stim` keeps its value.
- R3: On a rising edge with `mode_pg` low, `pin_data` is loaded into the stimulus register and the page register keeps its value.
- R4: `stim` is driven directly by the stimulus register. It changes only on a clock edge.
- R5: For a page value p below 54, `out_pins[k]` equals `result_bus[8*p+k]` for each k from 0 to 7.
- R6: `pin_data[0]` is loaded into bit 0 of the selected register, and `pin_data[5]` into bit 5.
- R7: Page values 54 through 63 drive all eight output pins to 0.
- R8: `out_pins` is combinational from the page register and `result_bus`. A change on the result bus shows up on the outputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock (pin 0) |
| rst | input | 1 | Synchronous active-high reset |
| mode_pg | input | 1 | High: the edge loads the page register. Low: the edge loads the stimulus register. |
| pin_data | input | 6 | Shared data pins (pins 2 to 7, with bit 0 on pin 2) |
| result_bus | input | 432 | Result bits from the units under test, grouped as 54 pages of 8 |
| stim | output | 6 | Stimulus sent to every unit under test |
| out_pins | output | 8 | The eight result bits of the selected page |

## Verification
The assertions assume that `mode_pg` and `pin_data` are stable at each rising edge, so that every edge loads exactly one known value. They also assume that reset is held for at least one edge before any checking begins. The bench changes all inputs only on falling edges and holds reset for two edges. It fills the result bus with patterns that differ from page to page, so a wrong page or a wrong lane order shows up as a mismatch. It drives page values both inside and outside the populated range, including 53, 54 and 63.

// File: rtl/pgsel_pkg.sv
package pgsel_pkg;
  localparam int unsigned DEF_DATA_W = 6;
  localparam int unsigned DEF_LANES  = 8;
  localparam int unsigned DEF_PAGES  = 54;

  // True when a page number addresses a populated group of results.
  function automatic bit page_valid(input int unsigned page, input int unsigned pages);
    return page < pages;
  endfunction

  // Flat result-bus index of a lane within a page.
  function automatic int unsigned lane_index(input int unsigned page, input int unsigned lane,
                                             input int unsigned lanes);
    return page * lanes + lane;
  endfunction
endpackage

// File: rtl/pgsel_steer.sv
// Turns the sampled mode pin into two mutually exclusive load strobes.
module pgsel_steer (
  input  logic mode_pg,
  output logic ld_page,
  output logic ld_stim
);
  always_comb begin
    ld_page = mode_pg;
    ld_stim = ~mode_pg;
  end
endmodule

// File: rtl/pgsel_reg.sv
// Loadable register with synchronous clear; holds when not loaded.
module pgsel_reg #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/pgsel_mux.sv
// Combinational page selector: one generated selector per output lane.
module pgsel_mux #(
  parameter int unsigned SEL_W = 6,
  parameter int unsigned LANES = 8,
  parameter int unsigned PAGES = 54
) (
  input  logic [SEL_W-1:0]       sel,
  input  logic [LANES*PAGES-1:0] res,
  output logic [LANES-1:0]       out
);
  import pgsel_pkg::*;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      out[k] = 1'b0;
      for (int unsigned p = 0; p < PAGES; p++) begin
        if (sel == SEL_W'(p))
          out[k] = res[lane_index(p, k, LANES)];
      end
    end
  end
endmodule

// File: rtl/page_sel_front.sv
// Pin front end: steers shared data pins into a page or a stimulus register.
module page_sel_front #(
  parameter int unsigned DATA_W = pgsel_pkg::DEF_DATA_W,
  parameter int unsigned LANES  = pgsel_pkg::DEF_LANES,
  parameter int unsigned PAGES  = pgsel_pkg::DEF_PAGES,
  localparam int unsigned RES_W = LANES * PAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_pg,
  input  logic [DATA_W-1:0] pin_data,
  input  logic [RES_W-1:0]  result_bus,
  output logic [DATA_W-1:0] stim,
  output logic [LANES-1:0]  out_pins
);
  // Named internal events, visible to the bound checker.
  logic              ld_page;
  logic              ld_stim;
  logic [DATA_W-1:0] page_q;

  pgsel_steer u_steer (
    .mode_pg (mode_pg),
    .ld_page (ld_page),
    .ld_stim (ld_stim)
  );

  pgsel_reg #(.W(DATA_W)) u_page_reg (
    .clk (clk), .rst (rst), .ld (ld_page), .d (pin_data), .q (page_q)
  );

  pgsel_reg #(.W(DATA_W)) u_stim_reg (
    .clk (clk), .rst (rst), .ld (ld_stim), .d (pin_data), .q (stim)
  );

  pgsel_mux #(.SEL_W(DATA_W), .LANES(LANES), .PAGES(PAGES)) u_mux (
    .sel (page_q), .res (result_bus), .out (out_pins)
  );
endmodule

// File: rtl/pgsel_chk.sv
// Assertion checker, bound to the top module.
module pgsel_chk #(
  parameter int unsigned DATA_W = 6,
  parameter int unsigned LANES  = 8,
  parameter int unsigned PAGES  = 54
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_pg,
  input logic [DATA_W-1:0] pin_data,
  input logic [DATA_W-1:0] stim,
  input logic [DATA_W-1:0] page_q,
  input logic [LANES-1:0]  out_pins
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (stim == '0 && page_q == '0));

  a_r2_page_load: assert property (@(posedge clk) disable iff (rst)
    mode_pg |=> page_q == $past(pin_data));

  a_r2_stim_hold: assert property (@(posedge clk) disable iff (rst)
    mode_pg |=> $stable(stim));

  a_r3_stim_load: assert property (@(posedge clk) disable iff (rst)
    !mode_pg |=> stim == $past(pin_data));

  a_r3_page_hold: assert property (@(posedge clk) disable iff (rst)
    !mode_pg |=> $stable(page_q));

  a_r7_unpopulated_zero: assert property (@(negedge clk) disable iff (rst)
    (int'(page_q) >= int'(PAGES)) |-> out_pins == '0);
endmodule

bind page_sel_front pgsel_chk #(.DATA_W(DATA_W), .LANES(LANES), .PAGES(PAGES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_pg  (mode_pg),
  .pin_data (pin_data),
  .stim     (stim),
  .page_q   (page_q),
  .out_pins (out_pins)
);

// File: tb/page_sel_front_tb.sv
module page_sel_front_tb;
  localparam int DW = 6, LN = 8, PG = 54, RW = LN * PG;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_pg = 1'b0;
  logic [DW-1:0] pin_data = '0;
  logic [RW-1:0] result_bus = '0;
  logic [DW-1:0] stim;
  logic [LN-1:0] out_pins;

  int total = 0;
  int bad = 0;
  int pg_m = 0;
  logic [DW-1:0] st_m = '0;

  always #2 clk = ~clk;

  page_sel_front u_dut (
    .clk (clk), .rst (rst), .mode_pg (mode_pg), .pin_data (pin_data),
    .result_bus (result_bus), .stim (stim), .out_pins (out_pins)
  );

  // Each vector: {mode, data[5:0]}.
  localparam logic [6:0] VEC [12] = '{
    7'b1_000011, 7'b0_101010, 7'b0_010101, 7'b1_110101, 7'b0_000001,
    7'b1_000001, 7'b1_100000, 7'b0_100000, 7'b1_110110, 7'b1_111111,
    7'b0_111111, 7'b1_011001
  };

  function automatic logic [RW-1:0] pattern(input int salt);
    logic [RW-1:0] v;
    for (int i = 0; i < RW; i++) v[i] = ((i * 13 + salt + (i / 8) * 5) % 7) < 3;
    return v;
  endfunction

  function automatic logic [LN-1:0] expect_out(input int p, input logic [RW-1:0] rb);
    logic [LN-1:0] e;
    e = '0;
    if (p < PG) for (int k = 0; k < LN; k++) e[k] = rb[p * LN + k];
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic [DW-1:0] d);
    @(negedge clk);
    mode_pg = m;
    pin_data = d;
    @(posedge clk);
    if (m) pg_m = int'(d); else st_m = d;
    #1;
  endtask

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    result_bus = pattern(1);
    rst = 1'b1;
    mode_pg = 1'b1;
    pin_data = 6'h2a;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 stim after reset", 32'(stim), 32'h0);
    chk("R1 page 0 after reset", 32'(out_pins), 32'(expect_out(0, result_bus)));
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][6], VEC[i][5:0]);
      chk(VEC[i][6] ? "R2 stim held on page load" : "R3 R4 stim loaded", 32'(stim), 32'(st_m));
      chk(VEC[i][6] ? "R2 R5 page selected" : "R3 page held", 32'(out_pins),
          32'(expect_out(pg_m, result_bus)));
    end

    // R6: single-bit ordering.
    step(1'b0, 6'b000001);
    chk("R6 pin bit0 to stim bit0", 32'(stim), 32'h01);
    step(1'b0, 6'b100000);
    chk("R6 pin bit5 to stim bit5", 32'(stim), 32'h20);
    step(1'b1, 6'b000001);
    chk("R6 page bit0 selects page 1", 32'(out_pins), 32'(result_bus[15:8]));

    // R5 / R7 boundaries.
    step(1'b1, 6'd53);
    chk("R5 last page 53", 32'(out_pins), 32'(result_bus[RW-1 -: 8]));
    result_bus = '1;
    #1;
    chk("R8 comb update without clock", 32'(out_pins), 32'hff);
    step(1'b1, 6'd54);
    chk("R7 page 54 zero", 32'(out_pins), 32'h0);
    step(1'b1, 6'd63);
    chk("R7 page 63 zero", 32'(out_pins), 32'h0);
    step(1'b0, 6'h15);
    chk("R7 page held out of range", 32'(out_pins), 32'h0);
    chk("R3 stim loaded while out of range", 32'(stim), 32'h15);

    // R8: result change with page 0.
    step(1'b1, 6'd0);
    result_bus = pattern(4);
    #1;
    chk("R8 page 0 follows new results", 32'(out_pins), 32'(expect_out(0, result_bus)));

    // R1: reset mid-run.
    @(negedge clk);
    rst = 1'b1;
    mode_pg = 1'b1;
    pin_data = 6'd9;
    @(posedge clk);
    #1;
    chk("R1 stim cleared mid-run", 32'(stim), 32'h0);
    chk("R1 page cleared mid-run", 32'(out_pins), 32'(expect_out(0, result_bus)));
    @(negedge clk);
    rst = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule